// File: doc/BRIEF.md
# Fetch-Stage Branch Target Cache with Target-Instruction Folding

This block is a small fully associative cache keyed by the address of a branch instruction. During fetch the current program counter is compared against every stored tag in the same cycle. On a match the block returns the remembered branch destination and offers it as the next fetch address. The redirect is therefore in place before the fetched word has been decoded. On a miss the next fetch address is the sequential one.

When folding is enabled at build time, each entry also keeps the instruction word that sits at the branch destination. If the matching entry is marked unconditional, that word is handed to decode in place of the branch. Fetch then moves on to the address just past the destination, so the branch costs no cycle at all. Conditional entries only redirect and still send the branch down the pipe to be verified.

Entries are written when a branch resolves later in the pipe. A taken resolution installs or refreshes the entry. A not-taken resolution removes the entry.

Top module: `btb_fold_top`

## Requirements
- R1: After reset no entry is valid. Every lookup gives hit_o=0 and fold_o=0, and next_pc_o equals fetch_pc_i+PC_STEP (PC_STEP=4).
- R2: On a miss, hit_o=0, fold_o=0, target_o=0 and next_pc_o=fetch_pc_i+PC_STEP.
- R3: On a hit, hit_o=1 and target_o equals the destination most recently recorded for that branch address. Both are combinational in the cycle the address is presented.
- R4: A resolution presented in cycle t changes lookups only from cycle t+1 onward. A lookup of the same address in cycle t still sees the old contents.
- R5: A taken resolution whose address is already stored overwrites that entry in place. It does not advance the replacement pointer, and it never creates a second entry for the same address.
- R6: A taken resolution for an address that is not stored is written into the slot under a round-robin pointer. The pointer starts at slot 0 after reset and advances by one after each such write, wrapping after ENTRIES-1. The entry in that slot is evicted whether or not it was valid.
- R7: A not-taken resolution invalidates the entry for its address, so later lookups of that address miss. Other entries and the replacement pointer are unchanged. A not-taken resolution for an address that is not stored has no effect.
- R8: With FOLD_EN=1, a hit on an entry recorded with upd_uncond_i=1 drives fold_o=1. It also drives fold_instr_o to the recorded target word and next_pc_o to target+PC_STEP.
- R9: A hit on an entry recorded with upd_uncond_i=0 drives fold_o=0 and next_pc_o equal to target_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_pc_i | input | PC_W | Address being fetched this cycle |
| hit_o | output | 1 | A stored entry matches fetch_pc_i |
| target_o | output | PC_W | Recorded destination on a hit, zero otherwise |
| fold_o | output | 1 | Target word replaces the branch this cycle |
| fold_instr_o | output | INSTR_W | Word at the destination when fold_o is set |
| next_pc_o | output | PC_W | Address to fetch in the next cycle |
| upd_valid_i | input | 1 | A resolved branch is being reported |
| upd_pc_i | input | PC_W | Address of the resolved branch |
| upd_taken_i | input | 1 | 1 installs or refreshes the entry, 0 removes it |
| upd_target_i | input | PC_W | Resolved destination |
| upd_uncond_i | input | 1 | Branch is unconditional |
| upd_instr_i | input | INSTR_W | Instruction word found at the destination |

## Verification
All lookup results (hit_o, target_o, fold_o, fold_instr_o, next_pc_o) are due in the same cycle that fetch_pc_i is presented. The bench drives the address on the falling edge and samples 2 ns later, before the next rising edge. A resolution is driven on a falling edge and is expected to be visible only after the following rising edge. The bench therefore runs a full sweep of eight branch addresses only once a resolution has been clocked in. It also makes one same-cycle lookup while an install is still pending, to confirm the old contents are still returned.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    UPD_NONE    = 2'd0,
    UPD_INSTALL = 2'd1,
    UPD_DROP    = 2'd2
  } upd_kind_e;
endpackage

// File: rtl/btb_entry_array.sv
module btb_entry_array
  import btb_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int PC_W    = 32,
  parameter int INSTR_W = 32,
  parameter bit FOLD_EN = 1'b1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  upd_kind_e                         kind_i,
  input  logic [PC_W-1:0]                   upd_pc_i,
  input  logic [PC_W-1:0]                   upd_target_i,
  input  logic                              upd_uncond_i,
  input  logic [INSTR_W-1:0]                upd_instr_i,
  output logic [ENTRIES-1:0]                valid_o,
  output logic [ENTRIES-1:0][PC_W-1:0]      tag_o,
  output logic [ENTRIES-1:0][PC_W-1:0]      tgt_o,
  output logic [ENTRIES-1:0]                unc_o,
  output logic [ENTRIES-1:0][INSTR_W-1:0]   ins_o
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0]              valid_q;
  logic [ENTRIES-1:0][PC_W-1:0]    tag_q, tgt_q;
  logic [ENTRIES-1:0]              unc_q;
  logic [IDX_W-1:0]                rr_q;
  logic                            upd_hit;
  logic [IDX_W-1:0]                upd_idx;

  // write-side match, independent of the fetch-side compare
  always_comb begin
    upd_hit = 1'b0;
    upd_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (valid_q[i] && tag_q[i] == upd_pc_i) begin
        upd_hit = 1'b1;
        upd_idx = IDX_W'(i);
      end
    end
  end

  logic [IDX_W-1:0] wr_idx;
  assign wr_idx = upd_hit ? upd_idx : rr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      tag_q   <= '0;
      tgt_q   <= '0;
      unc_q   <= '0;
      rr_q    <= '0;
    end else begin
      unique case (kind_i)
        UPD_INSTALL: begin
          valid_q[wr_idx] <= 1'b1;
          tag_q[wr_idx]   <= upd_pc_i;
          tgt_q[wr_idx]   <= upd_target_i;
          unc_q[wr_idx]   <= upd_uncond_i;
          if (!upd_hit) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
        end
        UPD_DROP: if (upd_hit) valid_q[upd_idx] <= 1'b0;
        default: ;
      endcase
    end
  end

  generate
    if (FOLD_EN) begin : g_fold_store
      logic [ENTRIES-1:0][INSTR_W-1:0] ins_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ins_q <= '0;
        else if (kind_i == UPD_INSTALL) ins_q[wr_idx] <= upd_instr_i;
      end
      assign ins_o = ins_q;
    end else begin : g_no_fold_store
      logic unused_instr;
      assign unused_instr = ^upd_instr_i;
      assign ins_o = '0;
    end
  endgenerate

  assign valid_o = valid_q;
  assign tag_o   = tag_q;
  assign tgt_o   = tgt_q;
  assign unc_o   = unc_q;
endmodule

// File: rtl/btb_lookup.sv
module btb_lookup #(
  parameter int ENTRIES = 4,
  parameter int PC_W    = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [PC_W-1:0]              pc_i,
  input  logic [ENTRIES-1:0]           valid_i,
  input  logic [ENTRIES-1:0][PC_W-1:0] tag_i,
  output logic [ENTRIES-1:0]           match_o,
  output logic                         hit_o,
  output logic [IDX_W-1:0]             idx_o
);
  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match_o[g] = valid_i[g] && (tag_i[g] == pc_i);
    end
  endgenerate

  always_comb begin
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_o[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |match_o;
endmodule

// File: rtl/btb_next_pc.sv
module btb_next_pc #(
  parameter int ENTRIES = 4,
  parameter int PC_W    = 32,
  parameter int INSTR_W = 32,
  parameter int PC_STEP = 4,
  parameter bit FOLD_EN = 1'b1,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [PC_W-1:0]                 pc_i,
  input  logic                            hit_i,
  input  logic [IDX_W-1:0]                idx_i,
  input  logic [ENTRIES-1:0][PC_W-1:0]    tgt_i,
  input  logic [ENTRIES-1:0]              unc_i,
  input  logic [ENTRIES-1:0][INSTR_W-1:0] ins_i,
  output logic [PC_W-1:0]                 target_o,
  output logic                            fold_o,
  output logic [INSTR_W-1:0]              fold_instr_o,
  output logic [PC_W-1:0]                 next_pc_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  logic [PC_W-1:0] sel_tgt;
  logic            fold;

  assign sel_tgt  = tgt_i[idx_i];
  assign fold     = FOLD_EN && hit_i && unc_i[idx_i];
  assign target_o = hit_i ? sel_tgt : '0;
  assign fold_o   = fold;
  assign fold_instr_o = fold ? ins_i[idx_i] : '0;

  always_comb begin
    if (fold)       next_pc_o = sel_tgt + STEP;  // target word already delivered
    else if (hit_i) next_pc_o = sel_tgt;
    else            next_pc_o = pc_i + STEP;
  end
endmodule

// File: rtl/btb_fold_top.sv
module btb_fold_top
  import btb_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int PC_W    = 32,
  parameter int INSTR_W = 32,
  parameter int PC_STEP = 4,
  parameter bit FOLD_EN = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PC_W-1:0]    fetch_pc_i,
  output logic               hit_o,
  output logic [PC_W-1:0]    target_o,
  output logic               fold_o,
  output logic [INSTR_W-1:0] fold_instr_o,
  output logic [PC_W-1:0]    next_pc_o,
  input  logic               upd_valid_i,
  input  logic [PC_W-1:0]    upd_pc_i,
  input  logic               upd_taken_i,
  input  logic [PC_W-1:0]    upd_target_i,
  input  logic               upd_uncond_i,
  input  logic [INSTR_W-1:0] upd_instr_i
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  upd_kind_e                         kind;
  logic [ENTRIES-1:0]                valid_vec;
  logic [ENTRIES-1:0][PC_W-1:0]      tag_vec, tgt_vec;
  logic [ENTRIES-1:0]                unc_vec;
  logic [ENTRIES-1:0][INSTR_W-1:0]   ins_vec;
  logic [ENTRIES-1:0]                match_vec;
  logic [IDX_W-1:0]                  hit_idx;
  logic                              hit;

  always_comb begin
    if (!upd_valid_i)     kind = UPD_NONE;
    else if (upd_taken_i) kind = UPD_INSTALL;
    else                  kind = UPD_DROP;
  end

  btb_entry_array #(
    .ENTRIES(ENTRIES), .PC_W(PC_W), .INSTR_W(INSTR_W), .FOLD_EN(FOLD_EN)
  ) u_array (
    .clk_i(clk_i), .rst_ni(rst_ni), .kind_i(kind),
    .upd_pc_i(upd_pc_i), .upd_target_i(upd_target_i),
    .upd_uncond_i(upd_uncond_i), .upd_instr_i(upd_instr_i),
    .valid_o(valid_vec), .tag_o(tag_vec), .tgt_o(tgt_vec),
    .unc_o(unc_vec), .ins_o(ins_vec)
  );

  btb_lookup #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_lookup (
    .pc_i(fetch_pc_i), .valid_i(valid_vec), .tag_i(tag_vec),
    .match_o(match_vec), .hit_o(hit), .idx_o(hit_idx)
  );

  btb_next_pc #(
    .ENTRIES(ENTRIES), .PC_W(PC_W), .INSTR_W(INSTR_W),
    .PC_STEP(PC_STEP), .FOLD_EN(FOLD_EN)
  ) u_next (
    .pc_i(fetch_pc_i), .hit_i(hit), .idx_i(hit_idx),
    .tgt_i(tgt_vec), .unc_i(unc_vec), .ins_i(ins_vec),
    .target_o(target_o), .fold_o(fold_o),
    .fold_instr_o(fold_instr_o), .next_pc_o(next_pc_o)
  );

  assign hit_o = hit;
endmodule

// File: rtl/btb_fold_chk.sv
module btb_fold_chk #(
  parameter int ENTRIES = 4,
  parameter int PC_W    = 32,
  parameter int PC_STEP = 4,
  parameter bit FOLD_EN = 1'b1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [PC_W-1:0]    fetch_pc_i,
  input logic               upd_valid_i,
  input logic               upd_taken_i,
  input logic [PC_W-1:0]    upd_pc_i,
  input logic [PC_W-1:0]    upd_target_i,
  input logic               hit_o,
  input logic [PC_W-1:0]    target_o,
  input logic               fold_o,
  input logic [PC_W-1:0]    next_pc_o,
  input logic [ENTRIES-1:0] match_vec
);
  assert_miss_seq_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (next_pc_o == fetch_pc_i + PC_W'(PC_STEP)) && (target_o == '0) && !fold_o);

  assert_install_seen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i) ##1 (fetch_pc_i == $past(upd_pc_i))
      |-> hit_o && (target_o == $past(upd_target_i)));

  assert_single_copy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_vec));

  assert_drop_misses_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !upd_taken_i) ##1 (fetch_pc_i == $past(upd_pc_i)) |-> !hit_o);

  assert_fold_needs_hit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fold_o |-> hit_o && (FOLD_EN != 1'b0) && (next_pc_o == target_o + PC_W'(PC_STEP)));

  assert_plain_hit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !fold_o) |-> next_pc_o == target_o);
endmodule

bind btb_fold_top btb_fold_chk #(
  .ENTRIES(ENTRIES), .PC_W(PC_W), .PC_STEP(PC_STEP), .FOLD_EN(FOLD_EN)
) u_chk (.*);

// File: tb/tb_btb_fold_top.sv
module tb_btb_fold_top;
  localparam int N = 4;
  localparam int PW = 32;
  localparam int IW = 32;
  localparam int NPC = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [PW-1:0] fetch_pc_i = '0;
  logic hit_o, fold_o;
  logic [PW-1:0] target_o, next_pc_o;
  logic [IW-1:0] fold_instr_o;
  logic upd_valid_i = 1'b0, upd_taken_i = 1'b0, upd_uncond_i = 1'b0;
  logic [PW-1:0] upd_pc_i = '0, upd_target_i = '0;
  logic [IW-1:0] upd_instr_i = '0;

  int checks = 0, errors = 0;

  // bench model from the requirements
  bit m_v[N];
  logic [PW-1:0] m_pc[N], m_tg[N];
  bit m_u[N];
  logic [IW-1:0] m_in[N];
  int m_rr = 0;

  always #4 clk_i = ~clk_i;

  btb_fold_top #(.ENTRIES(N), .PC_W(PW), .INSTR_W(IW), .PC_STEP(4), .FOLD_EN(1'b1)) dut (.*);

  function automatic logic [PW-1:0] bpc(int k); return 32'h100 + 32'h10 * k; endfunction

  task automatic chk(string r, logic [PW-1:0] act, logic [PW-1:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  task automatic look(int k, string r);
    bit eh = 0, ef = 0;
    logic [PW-1:0] et = '0, en;
    logic [IW-1:0] ei = '0;
    fetch_pc_i = bpc(k);
    #2;
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_pc[i] == bpc(k)) begin
        eh = 1; et = m_tg[i]; ef = m_u[i]; ei = ef ? m_in[i] : '0;
      end
    en = ef ? et + 4 : (eh ? et : bpc(k) + 4);
    chk(r, PW'(hit_o), PW'(eh), "hit");
    chk(r, target_o, et, "target");
    chk(r, PW'(fold_o), PW'(ef), "fold");
    chk(r, fold_instr_o, ei, "fold_instr");
    chk(r, next_pc_o, en, "next_pc");
  endtask

  task automatic sweep(string r);
    for (int k = 0; k < NPC; k++) begin
      @(negedge clk_i);
      look(k, r);
    end
  endtask

  task automatic resolve(int k, bit taken, logic [PW-1:0] tg, bit unc);
    int hi = -1;
    @(negedge clk_i);
    upd_valid_i = 1; upd_pc_i = bpc(k); upd_taken_i = taken;
    upd_target_i = tg; upd_uncond_i = unc; upd_instr_i = 32'hA000_0000 + k;
    look(k, "R4"); // old contents still visible this cycle
    for (int i = 0; i < N; i++) if (m_v[i] && m_pc[i] == bpc(k)) hi = i;
    if (taken) begin
      int w = (hi >= 0) ? hi : m_rr;
      m_v[w] = 1; m_pc[w] = bpc(k); m_tg[w] = tg; m_u[w] = unc; m_in[w] = upd_instr_i;
      if (hi < 0) m_rr = (m_rr + 1) % N;
    end else if (hi >= 0) m_v[hi] = 0;
    @(negedge clk_i);
    upd_valid_i = 0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) m_v[i] = 0;
    repeat (2) @(negedge clk_i);
    look(0, "R1");
    rst_ni = 1;
    sweep("R1");
    // fill all slots, odd ones unconditional (R3 R8 R9 R2)
    for (int k = 0; k < N; k++) resolve(k, 1, 32'h800 + 32'h20 * k, k[0]);
    sweep("R3_R8_R9");
    // refresh k=0 in place
    resolve(0, 1, 32'h900, 1'b0);
    sweep("R5");
    // new address evicts slot 0 (k=0); k=1 must remain
    resolve(4, 1, 32'h880, 1'b1);
    sweep("R6");
    // drop k=2, drop absent k=6
    resolve(2, 0, '0, 1'b0);
    resolve(6, 0, '0, 1'b0);
    sweep("R7");
    // pointer now at slot 1: evicts k=1 despite free slot 2
    resolve(5, 1, 32'h8A0, 1'b0);
    sweep("R6");
    resolve(7, 1, 32'h8E0, 1'b1);
    sweep("R2_R6");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule